// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a single-port synchronous memory whose inputs and read data both pass through registers. The data word is split into byte lanes. The shared data bus is split into three ports: `dq_in` for write data, `dq_out` for read data, and `dq_oe` to say when the core may drive the bus. An access is opened by one of two address strobes, one for a processor and one for a controller. It is qualified by three chip enables, two active low and one active high. After an access is opened, a small wraparound counter produces the following addresses of a four-beat burst, in either linear or interleaved order.

The two strobes treat writes differently. An access opened by the processor strobe always starts as a read, so a processor write completes on the next edge. An access opened by the controller strobe writes on the same edge. Writes are masked per byte lane, and a global write overrides the lane selects. The output enable is asynchronous. It is gated by a registered read-valid flag. That flag is cleared by write edges, by deselect edges and by the first read after the core leaves the deselected state.

Top module: `burst_sram_core`

## Requirements
- R1: A read taken at clock edge k puts the addressed word on `dq_out` after edge k+1. When `oe_n` is low, `dq_oe` is high for that cycle. Back-to-back reads deliver one word per cycle.
- R2: An access opens only on an edge where a recognised strobe is low and `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A recognised strobe with any enable inactive deselects the core. `dq_oe` is low in the cycle after a deselect edge, and no access runs until the next opening.
- R3: If both strobes are low on an edge where `ce1_n`=0, only the processor strobe counts. That edge is then a read, even with write controls active.
- R4: The processor strobe has no effect while `ce1_n`=1. The edge behaves as if that strobe were high.
- R5: An access opened by the processor strobe reads and ignores the write controls on that edge. Write controls on the next edge, with `advance_n` high, write the same address.
- R6: A controller strobe with the processor strobe high, the enables active and the write controls active writes on that same edge. `advance_n` has no effect on that edge.
- R7: `gwrite_n`=0 writes all lanes. Otherwise `bwrite_en_n`=0 writes each lane i whose `lane_sel_n[i]` is 0; lane i is `dq_in[8i+7:8i]`. Lanes that are not selected keep their contents. A write cycle needs at least one of these conditions to be true.
- R8: On any edge that performs a write, `dq_oe` goes low for the following cycle, whatever the value of `oe_n`.
- R9: The first read after an opening from the deselected state (including after reset) leaves `dq_oe` low even when `oe_n`=0.
- R10: After a write, a continuation edge with `advance_n` high and no write keeps `dq_oe` low. Reads resume on the next strobe edge or on an edge with `advance_n` low.
- R11: Each edge with `advance_n` low in an open access steps the burst counter. The two low address bits are then (base + n) mod 4 when `linear_mode`=1, and base XOR n when `linear_mode`=0. Here n counts the steps since the opening and wraps after the fourth beat. An edge with `advance_n` high keeps the current address.
- R12: `dq_oe` equals the registered read-valid flag AND NOT `oe_n`, following `oe_n` without a clock. It is low during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | ADDR_W | Word address, loaded on an opening edge |
| strobe_proc_n | input | 1 | Processor address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| advance_n | input | 1 | Burst step request, active low |
| gwrite_n | input | 1 | Global write, active low |
| bwrite_en_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| linear_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | High when the core may drive the bus |

## Verification
A wrong opening or deselect decision shows up as a `dq_oe` mismatch in the very next cycle. A wrong burst counter, or a wrong lane mask, corrupts either the word returned one cycle later or a word that is read back later. Because of this, every cycle is compared against a reference model that keeps its own byte-lane memory. A stale "selected" or "reading" state appears only on the first read after a deselect, or on a suspend cycle after a write. Those sequences are driven on purpose.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

  localparam int BURST_W = 2;

  typedef logic [BURST_W-1:0] beat_t;

  // Low address bits for beat n of a burst starting at base.
  function automatic beat_t beat_offset(input beat_t base, input beat_t n, input logic linear);
    return linear ? beat_t'(base + n) : (base ^ n);
  endfunction

endpackage

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr
  import sram_core_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  beat_t load_low,
  input  logic  step,
  input  logic  linear,
  output beat_t cur_low
);

  beat_t base_q;
  beat_t cnt_q;
  beat_t cnt_next;

  assign cnt_next = step ? beat_t'(cnt_q + 1'b1) : cnt_q;
  assign cur_low  = beat_offset(base_q, cnt_next, linear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_low;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q <= cnt_next;
    end
  end

  // R11: one step per advancing edge, wrapping
  assert_step_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == beat_t'($past(cnt_q) + 1'b1)));

  assert_load_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      q <= mem[rd_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/sram_access_ctl.sv
module sram_access_ctl
  import sram_core_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              advance_n,
  input  logic              gwrite_n,
  input  logic              bwrite_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  beat_t             burst_low,
  output logic              start_evt,
  output logic              step_evt,
  output logic              wr_evt,
  output logic [LANES-1:0]  wr_mask,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] rd_addr_q,
  output logic              rd_valid_q
);

  localparam int HI_W = ADDR_W - BURST_W;

  function automatic logic [LANES-1:0] lane_mask(input logic gw_n, input logic bwe_n,
                                                 input logic [LANES-1:0] sel_n);
    if (!gw_n)  return '1;
    if (!bwe_n) return ~sel_n;
    return '0;
  endfunction

  logic            sel_q;
  logic            read_mode_q;
  logic            rd_pend_q;
  logic [HI_W-1:0] hi_q;

  logic en_ok, proc_hit, ctrl_hit, ld_evt, desel_evt, cont_evt;
  logic wr_req, rd_evt, first_mask;

  assign en_ok     = !ce1_n && ce2 && !ce3_n;
  assign proc_hit  = !strobe_proc_n && !ce1_n;
  assign ctrl_hit  = !strobe_ctrl_n && !proc_hit;
  assign ld_evt    = proc_hit || ctrl_hit;
  assign start_evt = ld_evt && en_ok;
  assign desel_evt = ld_evt && !en_ok;
  assign cont_evt  = !ld_evt && sel_q;
  assign step_evt  = cont_evt && !advance_n;

  assign wr_mask   = lane_mask(gwrite_n, bwrite_en_n, lane_sel_n);
  assign wr_req    = |wr_mask;
  assign acc_addr  = start_evt ? addr : {hi_q, burst_low};
  assign wr_evt    = ((start_evt && ctrl_hit) || cont_evt) && wr_req;
  assign rd_evt    = (start_evt || cont_evt) && !wr_evt &&
                     (start_evt || !advance_n || read_mode_q);
  assign first_mask = start_evt && !sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= 1'b0;
      read_mode_q <= 1'b0;
      rd_pend_q   <= 1'b0;
      rd_valid_q  <= 1'b0;
      hi_q        <= '0;
      rd_addr_q   <= '0;
    end else begin
      if (start_evt)      sel_q <= 1'b1;
      else if (desel_evt) sel_q <= 1'b0;

      if (desel_evt)                  read_mode_q <= 1'b0;
      else if (start_evt || cont_evt) read_mode_q <= rd_evt;

      if (start_evt) hi_q <= addr[ADDR_W-1:BURST_W];
      if (rd_evt)    rd_addr_q <= acc_addr;

      rd_pend_q  <= rd_evt && !first_mask;
      rd_valid_q <= rd_pend_q && !wr_evt && !desel_evt;
    end
  end

  // R8: a write edge silences the bus next cycle
  assert_write_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !rd_valid_q);

  // R2: a deselect edge silences the bus next cycle
  assert_desel_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desel_evt |=> !rd_valid_q);

  // R3: both strobes with ce1_n low never write
  assert_proc_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_proc_n && !strobe_ctrl_n && !ce1_n) |-> !wr_evt);

  // R9: first read after leaving deselect stays hidden
  assert_first_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !sel_q) |=> ##1 !rd_valid_q);

  // R1: a valid output always follows a read two edges earlier
  assert_read_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> $past(rd_evt, 2));

  // R7: global write covers every lane
  assert_global_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !gwrite_n) |-> (wr_mask == '1));

  // R6: controller write lands on the presented address
  assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_proc_n && !strobe_ctrl_n && en_ok && wr_req) |-> (wr_evt && acc_addr == addr));

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import sram_core_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strobe_proc_n,
  input  logic                    strobe_ctrl_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    advance_n,
  input  logic                    gwrite_n,
  input  logic                    bwrite_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    linear_mode,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  beat_t              burst_low;
  logic               start_evt, step_evt, wr_evt, rd_valid_q;
  logic [LANES-1:0]   wr_mask;
  logic [ADDR_W-1:0]  acc_addr, rd_addr_q;

  sram_access_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .strobe_proc_n(strobe_proc_n),
    .strobe_ctrl_n(strobe_ctrl_n),
    .ce1_n        (ce1_n),
    .ce2          (ce2),
    .ce3_n        (ce3_n),
    .advance_n    (advance_n),
    .gwrite_n     (gwrite_n),
    .bwrite_en_n  (bwrite_en_n),
    .lane_sel_n   (lane_sel_n),
    .burst_low    (burst_low),
    .start_evt    (start_evt),
    .step_evt     (step_evt),
    .wr_evt       (wr_evt),
    .wr_mask      (wr_mask),
    .acc_addr     (acc_addr),
    .rd_addr_q    (rd_addr_q),
    .rd_valid_q   (rd_valid_q)
  );

  sram_burst_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_evt),
    .load_low(addr[BURST_W-1:0]),
    .step    (step_evt),
    .linear  (linear_mode),
    .cur_low (burst_low)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk    (clk),
    .wr_en  (wr_evt),
    .wr_mask(wr_mask),
    .wr_addr(acc_addr),
    .wr_data(dq_in),
    .rd_addr(rd_addr_q),
    .rd_data(dq_out)
  );

  assign dq_oe = rd_valid_q && !oe_n;

  // R12: the bus is never driven while oe_n is high
  assert_oe_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !oe_n);

endmodule

// File: tb/sim_burst_sram_core.sv
module sim_burst_sram_core;

  localparam int PERIOD = 10;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 8;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          strobe_proc_n = 1'b1, strobe_ctrl_n = 1'b1;
  logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic          advance_n = 1'b1, gwrite_n = 1'b1, bwrite_en_n = 1'b1;
  logic [NL-1:0] lane_sel_n = '1;
  logic          linear_mode = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #(PERIOD/2) clk = ~clk;

  burst_sram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (.*);

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R12";

  // reference model state
  logic [DW-1:0] ref_mem [0:(1<<AW)-1];
  bit            m_sel, m_rmode, m_pend, m_flag;
  int            m_base, m_cnt, m_hi, m_pend_addr;
  logic [DW-1:0] m_data;

  task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit en, p, c, started, was_sel, wreq, w, rd, kill;
    int a;
    logic [NL-1:0] mask;
    m_flag = m_pend;
    m_data = ref_mem[m_pend_addr];
    en = !ce1_n && ce2 && !ce3_n;
    p = !strobe_proc_n && !ce1_n;
    c = !strobe_ctrl_n && !p;
    if (!gwrite_n) mask = '1;
    else if (!bwrite_en_n) mask = ~lane_sel_n;
    else mask = '0;
    wreq = (mask != 0);
    started = 0; was_sel = m_sel; w = 0; a = 0;
    if (p || c) begin
      if (!en) begin
        m_sel = 0; m_rmode = 0; m_pend = 0; m_flag = 0;
        return;
      end
      started = 1; m_sel = 1;
      m_hi = int'(addr) / 4; m_base = int'(addr) % 4; m_cnt = 0;
      a = int'(addr);
      w = c && wreq;
    end else if (m_sel) begin
      if (!advance_n) m_cnt = (m_cnt + 1) % 4;
      a = m_hi * 4 + (linear_mode ? (m_base + m_cnt) % 4 : (m_base ^ m_cnt));
      w = wreq;
    end else begin
      m_pend = 0;
      return;
    end
    kill = w;
    if (kill) m_flag = 0;
    if (w) begin
      for (int i = 0; i < NL; i++)
        if (mask[i]) ref_mem[a][i*LW +: LW] = dq_in[i*LW +: LW];
      m_pend = 0; m_rmode = 0;
    end else begin
      rd = started || !advance_n || m_rmode;
      m_rmode = rd;
      m_pend = rd && !(started && !was_sel);
      if (rd) m_pend_addr = a;
    end
  endtask

  task automatic compare();
    bit exp_drive;
    exp_drive = m_flag && !oe_n;
    check(dq_oe === exp_drive, "dq_oe", DW'(dq_oe), DW'(exp_drive));
    if (exp_drive) check(dq_out === m_data, "dq_out", dq_out, m_data);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #(PERIOD/4);
    compare();
    @(negedge clk);
  endtask

  task automatic quiet();
    strobe_proc_n = 1; strobe_ctrl_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    advance_n = 1; gwrite_n = 1; bwrite_en_n = 1; lane_sel_n = '1; dq_in = '0;
  endtask

  task automatic ctrl_wr(input int a, input logic [DW-1:0] d, input bit gw, input bit bwe, input logic [NL-1:0] sel);
    quiet(); strobe_ctrl_n = 0; addr = AW'(a); dq_in = d;
    gwrite_n = gw; bwrite_en_n = bwe; lane_sel_n = sel; tick();
  endtask

  task automatic ctrl_rd(input int a);
    quiet(); strobe_ctrl_n = 0; addr = AW'(a); tick();
  endtask

  task automatic proc_go(input int a, input bit wr_ctl);
    quiet(); strobe_proc_n = 0; addr = AW'(a);
    if (wr_ctl) gwrite_n = 0;
    tick();
  endtask

  task automatic cont(input bit adv_n, input bit gw, input logic [DW-1:0] d);
    quiet(); advance_n = adv_n; gwrite_n = gw; dq_in = d; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
    m_sel = 0; m_rmode = 0; m_pend = 0; m_flag = 0;
    m_base = 0; m_cnt = 0; m_hi = 0; m_pend_addr = 0; m_data = '0;
    repeat (3) @(negedge clk);
    cur_req = "R12";
    check(dq_oe === 1'b0, "dq_oe in reset", DW'(dq_oe), '0);
    rst_n = 1;
    oe_n = 1;

    // R6: fill the words used by the tests with single-edge controller writes
    cur_req = "R6";
    for (int i = 0; i < 32; i++) ctrl_wr(i, DW'(i) * 32'h01030507 + 32'h10000000, 0, 1, '1);
    quiet(); strobe_ctrl_n = 0; addr = 8'd40; advance_n = 0; gwrite_n = 0; dq_in = 32'hCAFE0040; tick();
    oe_n = 0;
    ctrl_rd(40); cont(1, 1, '0);

    // R9: first read after deselect is hidden, then R11 linear burst
    cur_req = "R9";
    quiet(); strobe_ctrl_n = 0; ce2 = 0; tick();
    proc_go(4, 0);
    cur_req = "R11";
    linear_mode = 1;
    proc_go(6, 0); cont(0, 1, '0); cont(0, 1, '0); cont(0, 1, '0); cont(0, 1, '0);

    // R1: back-to-back reads
    cur_req = "R1";
    ctrl_rd(9); ctrl_rd(10); ctrl_rd(11); proc_go(12, 0);

    // R11: interleaved order and suspend
    cur_req = "R11";
    linear_mode = 0;
    proc_go(14, 0); cont(0, 1, '0); cont(0, 1, '0); cont(0, 1, '0); cont(0, 1, '0);
    cont(1, 1, '0); cont(1, 1, '0);
    linear_mode = 1;

    // R5: processor write takes two edges
    cur_req = "R5";
    proc_go(20, 1);
    cont(1, 0, 32'hDEAD0020);
    proc_go(20, 0); cont(1, 1, '0);

    // R7: byte lanes and global override
    cur_req = "R7";
    ctrl_wr(21, 32'hAABBCCDD, 1, 0, 4'b1010);
    ctrl_wr(22, 32'h11223344, 0, 1, 4'b1111);
    ctrl_wr(23, 32'h55667788, 0, 0, 4'b0111);
    ctrl_wr(24, 32'h99999999, 1, 1, 4'b0000);
    ctrl_rd(21); ctrl_rd(22); ctrl_rd(23); ctrl_rd(24); cont(1, 1, '0);

    // R3: both strobes, write controls ignored
    cur_req = "R3";
    quiet(); strobe_proc_n = 0; strobe_ctrl_n = 0; addr = 8'd25; gwrite_n = 0; dq_in = 32'h0BAD0025; tick();
    ctrl_rd(25); cont(1, 1, '0);

    // R4: processor strobe with ce1_n high
    cur_req = "R4";
    proc_go(26, 0);
    quiet(); strobe_proc_n = 0; ce1_n = 1; addr = 8'd2; advance_n = 0; tick();
    cont(1, 1, '0);
    quiet(); strobe_proc_n = 0; strobe_ctrl_n = 0; ce1_n = 1; addr = 8'd3; tick();
    cont(0, 1, '0);
    ctrl_rd(3);

    // R8: write edge silences pending read
    cur_req = "R8";
    ctrl_rd(3); ctrl_wr(3, 32'h33333333, 0, 1, '1); ctrl_rd(3); cont(1, 1, '0);

    // R10: after write, suspend stays quiet, advance resumes
    cur_req = "R10";
    ctrl_wr(28, 32'h28282828, 0, 1, '1); cont(1, 1, '0); cont(1, 1, '0); cont(0, 1, '0); cont(1, 1, '0);

    // R12: asynchronous output enable
    cur_req = "R12";
    ctrl_rd(9); oe_n = 1; ctrl_rd(10); ctrl_rd(11); oe_n = 0; cont(1, 1, '0);
    #(PERIOD/4); check(dq_oe === 1'b1, "dq_oe with oe_n low", DW'(dq_oe), DW'(1));
    oe_n = 1; #1; check(dq_oe === 1'b0, "dq_oe follows oe_n", DW'(dq_oe), '0);
    oe_n = 0; @(negedge clk);

    // R2: enable combinations
    cur_req = "R2";
    ctrl_rd(5);
    quiet(); strobe_ctrl_n = 0; ce3_n = 1; tick();
    cont(0, 1, '0); cont(1, 0, 32'h77777777);
    quiet(); strobe_proc_n = 0; ce2 = 0; tick();
    ctrl_rd(5); ctrl_rd(6); cont(0, 1, '0);
    quiet(); tick(); tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule